// File: doc/BRIEF.md
# Serial EEPROM Command and Write-Protect Controller

This block is the command and protection logic of a small serial EEPROM slave whose 128-byte array sits in internal registers. A host talks to it over SPI mode 0 using an active-low select, a serial clock, a data-in line and a data-out line. The block samples all three inputs with the system clock, decodes six instructions and answers reads on the data-out line. It holds a status byte with a busy flag, a write-enable latch and a two-bit protection field.

Every state-changing instruction is committed only at the moment select is released, and only if that release lands exactly on a byte boundary. The commit is also gated by the write-enable latch, by the busy flag and, for array writes, by the address range that the protection field locks. A committed write starts a programming interval of `PROG_CYCLES` system clocks. During that interval the status byte can still be polled.

The serial link is the only data path. It has no valid/ready pair and no back-pressure: the host sets the pace with the serial clock, and the block must keep up with every edge. Data moves most significant bit first. The block samples on the rising serial clock edge and changes data-out after the falling edge.

Top module: `eep_wp_ctrl`

## Requirements
- R1: Read-status (opcode 05h) returns the byte {1111b, protect[1:0], wel, wip}, with wip in bit 0, wel in bit 1 and protect in bits 3:2. Each further byte clocked in the same frame returns the live value again.
- R2: Reset clears wel, wip and the protect field, and zeroes the array. Opcode 06h sets wel and opcode 04h clears it.
- R3: Write (02h, address, data) and write-status (01h, data) change nothing and start no cycle while wel is 0. Write-status copies only data bits 3:2 into the protect field.
- R4: Protect value 00 locks nothing, 01 locks addresses 60h-7Fh, 10 locks 40h-7Fh and 11 locks the whole array. A write to a locked address leaves the array unchanged, starts no cycle and keeps wel.
- R5: An instruction takes effect only if select rises after a whole number of bytes, and only once at least its full length (1, 2 or 3 bytes) has arrived. Any other count leaves all state unchanged.
- R6: A committed write or write-status sets wip for PROG_CYCLES system clocks. It then clears wip and wel together.
- R7: While wip is 1, read returns zero bytes and write and write-status are ignored. Read-status keeps working.
- R8: Read (03h, address) returns the addressed byte, then the following bytes for as long as clocks continue, wrapping from 7Fh to 00h. Address bit 7 is ignored. Data-out is 0 while select is high.
- R9: In a write frame only the first data byte is stored. Further whole bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select; a frame lasts while it is low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The assertions assume that the serial pins are slow against the system clock. Each phase of the serial clock must last longer than the synchronizer delay plus two clocks, and data-in and select may change only while the serial clock is low. Under these conditions a select release can never land between a sampled clock edge and its data bit. The bench meets these conditions by holding every serial clock phase for six system clocks. It changes data-in and select only in the low phase, and it leaves idle gaps between frames.

// File: rtl/eep_wp_pkg.sv
package eep_wp_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_STAT,
    PH_STREAM,
    PH_IDLE
  } phase_t;

  // top2 holds the two most significant address bits
  function automatic logic range_locked(input logic [1:0] prot, input logic [1:0] top2);
    case (prot)
      2'b00:   range_locked = 1'b0;
      2'b01:   range_locked = (top2 == 2'b11);
      2'b10:   range_locked = top2[1];
      default: range_locked = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/eep_spi_front.sv
module eep_spi_front #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       frame_start,
  output logic       frame_end,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       on_boundary,
  output logic [1:0] nbytes,
  output logic       miso
);

  logic [SYNC-1:0] cs_s, sck_s, mosi_s;
  logic            cs_d, sck_d;
  logic            cs_now, active, sck_rise, sck_fall, mosi_now;
  logic [2:0]      bit_idx;
  logic [6:0]      rx_sh;
  logic [7:0]      tx_sh;
  logic            miso_q;

  assign cs_now      = cs_s[SYNC-1];
  assign mosi_now    = mosi_s[SYNC-1];
  assign active      = !cs_now;
  assign frame_start = cs_d && !cs_now;
  assign frame_end   = !cs_d && cs_now;
  assign sck_rise    = sck_s[SYNC-1] && !sck_d && active;
  assign sck_fall    = !sck_s[SYNC-1] && sck_d && active;
  assign on_boundary = (bit_idx == 3'd0);
  assign miso        = miso_q;

  // input synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= '1;
      sck_s  <= '0;
      mosi_s <= '0;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_s   <= {cs_s[SYNC-2:0], cs_n};
      sck_s  <= {sck_s[SYNC-2:0], sck};
      mosi_s <= {mosi_s[SYNC-2:0], mosi};
      cs_d   <= cs_now;
      sck_d  <= sck_s[SYNC-1];
    end
  end

  // receive side: bit position, byte count, byte strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx   <= '0;
      nbytes    <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (frame_start) begin
        bit_idx <= '0;
        nbytes  <= '0;
      end else if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_now};
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh, mosi_now};
          if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
        end
      end
    end
  end

  // transmit side: load on byte strobe, shift on falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (!active) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (tx_load) begin
      tx_sh <= tx_byte;
    end else if (sck_fall) begin
      miso_q <= tx_sh[7];
      tx_sh  <= {tx_sh[6:0], 1'b0};
    end
  end

  assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_now |=> !miso_q);

endmodule

// File: rtl/eep_array.sv
module eep_array import eep_wp_pkg::*; #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    prot,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          wr_taken
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic          locked;

  assign locked   = range_locked(prot, wr_addr[AW-1 -: 2]);
  assign wr_taken = wr_req && !locked;
  assign rd_data  = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_taken) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assert_top_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_taken && prot != 2'b00) |-> !wr_addr[AW-1] || prot == 2'b01 && !wr_addr[AW-2]);

endmodule

// File: rtl/eep_cmd.sv
module eep_cmd import eep_wp_pkg::*; #(
  parameter int AW          = 7,
  parameter int PROG_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          on_boundary,
  input  logic [1:0]    nbytes,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic [7:0]    rd_data,
  input  logic          wr_taken,
  output logic          tx_load,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] rd_addr,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [1:0]    prot
);

  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(PROG_CYCLES - 1);

  phase_t        phase_q;
  logic [7:0]    opc_q;
  logic          armed_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          wel_q, wip_q;
  logic [1:0]    bp_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    status;
  logic          commit_ok, wrsr_go;

  assign status    = {4'hF, bp_q, wel_q, wip_q};
  assign commit_ok = frame_end && on_boundary;
  assign wr_req    = commit_ok && opc_q == OP_WRITE && armed_q && wel_q && nbytes == 2'd3;
  assign wrsr_go   = commit_ok && opc_q == OP_WRSR && armed_q && wel_q && nbytes >= 2'd2;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign prot      = bp_q;
  assign tx_load   = byte_done;
  assign rd_addr   = (phase_q == PH_ADDR) ? rx_byte[AW-1:0] : addr_q;

  always_comb begin
    tx_byte = '0;
    if ((phase_q == PH_OPC && rx_byte == OP_RDSR) || phase_q == PH_STAT)
      tx_byte = status;
    else if ((phase_q == PH_ADDR && opc_q == OP_READ) || phase_q == PH_STREAM)
      tx_byte = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      opc_q   <= '0;
      armed_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      wel_q   <= 1'b0;
      wip_q   <= 1'b0;
      bp_q    <= '0;
      cnt_q   <= '0;
    end else begin
      // programming interval
      if (wip_q) begin
        if (cnt_q == LAST_CNT) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      // byte-level decode
      if (frame_start) begin
        phase_q <= PH_OPC;
        opc_q   <= '0;
        armed_q <= 1'b0;
      end else if (byte_done) begin
        case (phase_q)
          PH_OPC: begin
            opc_q <= rx_byte;
            case (rx_byte)
              OP_RDSR:  phase_q <= PH_STAT;
              OP_READ,
              OP_WRITE: phase_q <= wip_q ? PH_IDLE : PH_ADDR;
              OP_WRSR:  phase_q <= wip_q ? PH_IDLE : PH_DATA;
              default:  phase_q <= PH_IDLE;
            endcase
            armed_q <= !wip_q;
          end
          PH_ADDR: begin
            if (opc_q == OP_READ) begin
              addr_q  <= rx_byte[AW-1:0] + 1'b1;
              phase_q <= PH_STREAM;
            end else begin
              addr_q  <= rx_byte[AW-1:0];
              phase_q <= PH_DATA;
            end
          end
          PH_DATA: begin
            data_q  <= rx_byte;
            phase_q <= PH_IDLE;
          end
          PH_STREAM: addr_q <= addr_q + 1'b1;
          default: ;
        endcase
      end

      // frame-level commit
      if (commit_ok && nbytes != 2'd0) begin
        if (opc_q == OP_WREN) wel_q <= 1'b1;
        if (opc_q == OP_WRDI) wel_q <= 1'b0;
      end
      if (wrsr_go) begin
        bp_q  <= data_q[3:2];
        wip_q <= 1'b1;
        cnt_q <= '0;
      end
      if (wr_taken) begin
        wip_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> $past(wel_q));

  assert_start_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> $past(frame_end && on_boundary));

  assert_end_clears_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_q) |-> (!wel_q || $past(frame_end)));

  assert_prot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wip_q |=> $stable(bp_q));

endmodule

// File: rtl/eep_wp_ctrl.sv
module eep_wp_ctrl #(
  parameter int AW          = 7,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);

  localparam int DW = 8;

  logic          frame_start, frame_end, byte_done, on_boundary;
  logic [1:0]    nbytes, prot;
  logic [DW-1:0] rx_byte, tx_byte, rd_data, wr_data;
  logic          tx_load, wr_req, wr_taken;
  logic [AW-1:0] rd_addr, wr_addr;

  eep_spi_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst_n(rst_n),
    .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .frame_start(frame_start), .frame_end(frame_end),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .on_boundary(on_boundary), .nbytes(nbytes),
    .miso(spi_miso)
  );

  eep_cmd #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .on_boundary(on_boundary), .nbytes(nbytes),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .rd_data(rd_data), .wr_taken(wr_taken),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .rd_addr(rd_addr), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .prot(prot)
  );

  eep_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .prot(prot),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_taken(wr_taken)
  );

endmodule

// File: tb/sim_eep_wp_ctrl.sv
module sim_eep_wp_ctrl;
  localparam int AW     = 7;
  localparam int PROG   = 1500;
  localparam int HALF   = 6;
  localparam int SETTLE = PROG + 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int   n_cmp = 0, n_bad = 0;
  logic [7:0] mdl_mem [128];
  logic [1:0] mdl_bp;
  logic       mdl_wel;

  always #2 clk = ~clk;

  eep_wp_ctrl #(.AW(AW), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  function automatic logic [7:0] f_status(input logic [1:0] bp, input logic wel, input logic wip);
    return {4'hF, bp, wel, wip};
  endfunction

  function automatic logic f_locked(input logic [1:0] bp, input logic [6:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 7'h60;
      2'b10:   return a >= 7'h40;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [63:0] tx, output logic [63:0] rx);
    rx = '0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[nbits-1-i];
      tick(HALF);
      rx = {rx[62:0], miso};
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    tick(4 * HALF);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [63:0] rx;
    frame(16, 64'h0500, rx);
    st = rx[7:0];
  endtask

  task automatic op1(input logic [7:0] opc);
    logic [63:0] rx;
    frame(8, {56'h0, opc}, rx);
  endtask

  task automatic wren();
    op1(8'h06);
    mdl_wel = 1'b1;
  endtask

  task automatic wrdi();
    op1(8'h04);
    mdl_wel = 1'b0;
  endtask

  task automatic send_write(input logic [6:0] a, input logic [7:0] d);
    logic [63:0] rx;
    frame(24, {40'h0, 8'h02, 1'b0, a, d}, rx);
  endtask

  // write through the model: settles when a cycle starts
  task automatic write_commit(input logic [6:0] a, input logic [7:0] d);
    send_write(a, d);
    if (mdl_wel && !f_locked(mdl_bp, a)) begin
      mdl_mem[a] = d;
      mdl_wel = 1'b0;
      tick(SETTLE);
    end
  endtask

  task automatic wrsr_commit(input logic [7:0] d);
    logic [63:0] rx;
    frame(16, {48'h0, 8'h01, d}, rx);
    if (mdl_wel) begin
      mdl_bp  = d[3:2];
      mdl_wel = 1'b0;
      tick(SETTLE);
    end
  endtask

  task automatic read_n(input logic [7:0] a, input int n, output logic [63:0] data);
    logic [63:0] rx;
    logic [63:0] tx;
    tx = {48'h0, 8'h03, a} << (8 * n);
    frame(16 + 8 * n, tx, rx);
    data = rx & ((64'h1 << (8 * n)) - 64'h1);
  endtask

  function automatic logic [63:0] mdl_read(input logic [6:0] a, input int n);
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++) v = {v[55:0], mdl_mem[7'(a + 7'(k))]};
    return v;
  endfunction

  task automatic chk_status(input string req);
    logic [7:0] st;
    rdsr(st);
    chk(req, {56'h0, st}, {56'h0, f_status(mdl_bp, mdl_wel, 1'b0)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] rx;
    logic [7:0]  st;
    logic [6:0]  addrs [6];
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 128; i++) mdl_mem[i] = 8'h00;
    mdl_bp  = 2'b00;
    mdl_wel = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // reset state
    chk("R8 idle miso", {63'h0, miso}, 64'h0);
    rdsr(st);
    chk("R2 R1 reset status", {56'h0, st}, 64'hF0);
    read_n(8'h10, 1, rx);
    chk("R2 array zero after reset", rx, 64'h0);

    // writes rejected without the latch
    send_write(7'h10, 8'hA5);
    tick(SETTLE);
    read_n(8'h10, 1, rx);
    chk("R3 write without wel", rx, 64'h0);
    frame(16, 64'h010C, rx);
    chk_status("R3 write-status without wel");

    // latch set / clear
    wren();
    chk_status("R2 wel set");
    wrdi();
    chk_status("R2 wel cleared");

    // committed write and busy window
    wren();
    send_write(7'h10, 8'hA5);
    rdsr(st);
    chk("R6 busy after commit", {56'h0, st}, {56'h0, f_status(2'b00, 1'b1, 1'b1)});
    read_n(8'h10, 1, rx);
    chk("R7 read ignored while busy", rx, 64'h0);
    send_write(7'h11, 8'h5A);
    frame(24, 64'h050000, rx);
    chk("R1 repeated status in frame", rx[15:0], 64'hF3F3);
    tick(SETTLE);
    mdl_mem[7'h10] = 8'hA5;
    mdl_wel = 1'b0;
    chk_status("R6 wip and wel clear after cycle");
    read_n(8'h10, 2, rx);
    chk("R8 R7 data after cycle", rx, 64'hA500);

    // framing
    wren();
    frame(23, {40'h0, 24'h0230AB} >> 1, rx);
    tick(SETTLE);
    read_n(8'h30, 1, rx);
    chk("R5 23-bit write aborted", rx, 64'h0);
    chk_status("R5 state kept after 23 bits");
    frame(25, {39'h0, 24'h0230AB, 1'b0}, rx);
    tick(SETTLE);
    read_n(8'h30, 1, rx);
    chk("R5 25-bit write aborted", rx, 64'h0);
    frame(16, 64'h0230, rx);
    chk_status("R5 write without data byte");
    wrdi();
    frame(7, 64'h03, rx);
    chk_status("R5 7-bit enable ignored");
    frame(9, 64'h0C, rx);
    chk_status("R5 9-bit enable ignored");
    frame(16, 64'h0600, rx);
    mdl_wel = 1'b1;
    chk_status("R5 two-byte enable accepted");

    // extra data bytes
    frame(40, {24'h0, 8'h02, 8'h20, 8'h11, 8'h22, 8'h33}, rx);
    tick(SETTLE);
    mdl_mem[7'h20] = 8'h11;
    mdl_wel = 1'b0;
    read_n(8'h20, 2, rx);
    chk("R9 only first data byte stored", rx, 64'h1100);

    // protection ranges
    addrs[0] = 7'h00; addrs[1] = 7'h3F; addrs[2] = 7'h40;
    addrs[3] = 7'h5F; addrs[4] = 7'h60; addrs[5] = 7'h7F;
    for (int b = 1; b < 4; b++) begin
      wren();
      wrsr_commit({4'hA, 2'(b), 2'b11});
      chk_status("R3 R1 protect field written");
      for (int k = 0; k < 6; k++) begin
        logic lk;
        logic [7:0] d;
        lk = f_locked(mdl_bp, addrs[k]);
        d  = 8'(8'h40 + b * 8 + k);
        wren();
        send_write(addrs[k], d);
        rdsr(st);
        chk("R4 cycle start per range", {56'h0, st},
            {56'h0, f_status(mdl_bp, 1'b1, !lk)});
        if (!lk) begin
          mdl_mem[addrs[k]] = d;
          mdl_wel = 1'b0;
          tick(SETTLE);
        end else begin
          wrdi();
        end
        read_n({1'b0, addrs[k]}, 1, rx);
        chk("R4 array after write", rx, {56'h0, mdl_mem[addrs[k]]});
      end
    end
    wren();
    wrsr_commit(8'h00);

    // wrap
    wren();
    write_commit(7'h7F, 8'h77);
    read_n(8'h7E, 3, rx);
    chk("R8 read wraps", rx, mdl_read(7'h7E, 3));
    read_n(8'hFF, 1, rx);
    chk("R8 address bit 7 ignored", rx, 64'h77);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: wren();
        1: wrdi();
        2: wrsr_commit(8'($urandom));
        3: write_commit(7'($urandom), 8'($urandom));
        default: begin
          logic [6:0] a;
          int n;
          a = 7'($urandom);
          n = 1 + int'($urandom % 3);
          read_n({1'b0, a}, n, rx);
          chk("R8 random read", rx, mdl_read(a, n));
        end
      endcase
      chk_status("R1 random status");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule